// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit turns a decoded operand-addressing code into the address (or, for constants, the value) that an execution stage needs. A decoder presents the mode code, a byte/word size flag, the instruction's offset field, up to two register values and the current program counter, then pulses `start`. For register-based and constant modes the answer appears one clock later. For memory-indirect modes the unit issues its own data-memory reads over a valid/ready request channel and follows pointer chains until a fetched word has its indirect flag clear.

Autoincrement and autodecrement modes also produce a write-back request that carries the new base register value. The register file owns that write-back. A pointer chain that is still flagged after the allowed number of levels ends with an error rather than looping forever.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `err`, `wb_valid`, `mem_req_valid` and `busy` are all low.
- R2: Mode 0 (constant) returns the zero-extended `offset` as `result`, with `done` high in the cycle after `start` and no memory request.
- R3: Mode 1 (absolute) returns the zero-extended `offset` as `result` one cycle after `start`.
- R4: Mode 2 (register indirect) returns `reg_a` as `result` and issues no write-back.
- R5: Mode 3 (indexed) returns `reg_a` plus the sign-extended `offset`, and `wb_valid` stays low so the index register is left unchanged.
- R6: Mode 4 returns `reg_a + reg_b`, and mode 5 returns `reg_a + reg_b` plus the sign-extended `offset`.
- R7: Mode 6 (relative) returns `pc` plus the sign-extended `offset`.
- R8: Mode 7 (memory indirect) reads at the zero-extended `offset`. If the returned word has bit 31 clear, `done` pulses once with `result` equal to that word and `err` low.
- R9: When a fetched word has bit 31 set, the next read goes to that word with bit 31 cleared. No request address ever has bit 31 set.
- R10: If eight reads in a row all return words with bit 31 set, the unit stops with `done` and `err` high. `result` then holds the last word with bit 31 cleared, and no ninth read is issued.
- R11: Mode 8 (autoincrement) returns `reg_a` and raises `wb_valid` with `wb_value = reg_a + 1` when `size_byte` is 1, or `reg_a + 4` when it is 0.
- R12: Mode 9 (autodecrement) returns `reg_a - step` as both `result` and `wb_value`, with `wb_valid` high. The step is 1 for bytes and 4 for words.
- R13: A memory request that is not yet accepted keeps `mem_req_valid` high and `mem_req_addr` unchanged.
- R14: `start` is ignored while `busy` is high. Mode codes 10 to 15 complete with `err` high, `result` zero and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (taken only when not busy) |
| mode | input | 4 | Addressing-mode code |
| size_byte | input | 1 | 1 = byte access, 0 = word access |
| offset | input | 16 | Instruction offset / constant field |
| reg_a | input | 32 | Base or index register value |
| reg_b | input | 32 | Second register value |
| pc | input | 32 | Program counter |
| busy | output | 1 | Pointer-chain walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Effective address or constant |
| err | output | 1 | Completion with error (valid with done) |
| wb_valid | output | 1 | Base register write-back request |
| wb_value | output | 32 | New base register value |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
The assertions assume that memory answers only reads it has accepted, one at a time. `mem_rsp_valid` may therefore rise only while the walker waits for data, and never in the cycle of acceptance. The bench's memory model keeps to this rule. It raises `mem_req_ready` only while a request is visible, and it drives one response in the cycle after each acceptance. Chains of several lengths, the full eight-level limit, and a delayed accept are all run with this handshake timing.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [3:0] {
      EA_CONST  = 4'd0,
      EA_ABS    = 4'd1,
      EA_RIND   = 4'd2,
      EA_INDEX  = 4'd3,
      EA_BX     = 4'd4,
      EA_BXO    = 4'd5,
      EA_REL    = 4'd6,
      EA_MIND   = 4'd7,
      EA_POSTI  = 4'd8,
      EA_PRED   = 4'd9
   } ea_mode_e;

   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_REQ  = 2'd1,
      CH_WAIT = 2'd2
   } chain_st_e;

endpackage

// File: rtl/ea_calc.sv
module ea_calc
   import ea_pkg::*;
#(
   parameter int AW               = 32,
   parameter int OFF_W            = 16,
   parameter bit SIGNED_INDEX_OFF = 1'b1
) (
   input  logic [3:0]       mode,
   input  logic             size_byte,
   input  logic [OFF_W-1:0] offset,
   input  logic [AW-1:0]    reg_a,
   input  logic [AW-1:0]    reg_b,
   input  logic [AW-1:0]    pc,
   output logic [AW-1:0]    ea,
   output logic             wb_en,
   output logic [AW-1:0]    wb_val,
   output logic             need_mem,
   output logic             bad_mode
);

   localparam int WORD_STEP = AW / 8;
   localparam int EXT_W     = AW - OFF_W;

   logic [AW-1:0] off_z;
   logic [AW-1:0] off_s;
   logic [AW-1:0] off_x;
   logic [AW-1:0] step;
   logic [AW-1:0] pre_dec;
   logic [AW-1:0] post_inc;
   ea_mode_e      m;

   assign off_z = {{EXT_W{1'b0}}, offset};
   assign off_s = {{EXT_W{offset[OFF_W-1]}}, offset};

   generate
      if (SIGNED_INDEX_OFF) begin : g_idx_signed
         assign off_x = off_s;
      end else begin : g_idx_unsigned
         assign off_x = off_z;
      end
   endgenerate

   assign step     = size_byte ? AW'(1) : AW'(WORD_STEP);
   assign pre_dec  = reg_a - step;
   assign post_inc = reg_a + step;
   assign m        = ea_mode_e'(mode);

   always_comb begin
      ea       = '0;
      wb_en    = 1'b0;
      wb_val   = '0;
      need_mem = 1'b0;
      bad_mode = 1'b0;
      case (m)
         EA_CONST: ea = off_z;
         EA_ABS:   ea = off_z;
         EA_RIND:  ea = reg_a;
         EA_INDEX: ea = reg_a + off_x;
         EA_BX:    ea = reg_a + reg_b;
         EA_BXO:   ea = reg_a + reg_b + off_x;
         EA_REL:   ea = pc + off_s;
         EA_MIND: begin
            ea       = off_z;
            need_mem = 1'b1;
         end
         EA_POSTI: begin
            ea     = reg_a;
            wb_en  = 1'b1;
            wb_val = post_inc;
         end
         EA_PRED: begin
            ea     = pre_dec;
            wb_en  = 1'b1;
            wb_val = pre_dec;
         end
         default: bad_mode = 1'b1;
      endcase
   end

endmodule

// File: rtl/ea_chain.sv
module ea_chain
   import ea_pkg::*;
#(
   parameter int AW         = 32,
   parameter int FLAG_BIT   = AW - 1,
   parameter int MAX_LEVELS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] launch_addr,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [AW-1:0] mem_rsp_data,
   output logic          busy,
   output logic          fin,
   output logic [AW-1:0] fin_addr,
   output logic          fin_err
);

   localparam int            LVL_W     = $clog2(MAX_LEVELS + 1);
   localparam logic [AW-1:0] FLAG_MASK = ~(AW'(1) << FLAG_BIT);
   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(MAX_LEVELS);

   chain_st_e        st;
   logic [LVL_W-1:0] lvl;
   logic [AW-1:0]    addr_q;
   logic [AW-1:0]    masked;
   logic             flagged;

   assign masked        = mem_rsp_data & FLAG_MASK;
   assign flagged       = mem_rsp_data[FLAG_BIT];
   assign mem_req_valid = (st == CH_REQ);
   assign mem_req_addr  = addr_q;
   assign busy          = (st != CH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= CH_IDLE;
         lvl      <= '0;
         addr_q   <= '0;
         fin      <= 1'b0;
         fin_addr <= '0;
         fin_err  <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (st)
            CH_IDLE: begin
               if (launch) begin
                  addr_q <= launch_addr;
                  lvl    <= LVL_W'(1);
                  st     <= CH_REQ;
               end
            end
            CH_REQ: begin
               if (mem_req_ready) st <= CH_WAIT;
            end
            CH_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!flagged) begin
                     fin      <= 1'b1;
                     fin_addr <= masked;
                     fin_err  <= 1'b0;
                     st       <= CH_IDLE;
                  end else if (lvl == LVL_MAX) begin
                     fin      <= 1'b1;
                     fin_addr <= masked;
                     fin_err  <= 1'b1;
                     st       <= CH_IDLE;
                  end else begin
                     addr_q <= masked;
                     lvl    <= lvl + LVL_W'(1);
                     st     <= CH_REQ;
                  end
               end
            end
            default: st <= CH_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R13
   AST_REQ_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !mem_req_addr[FLAG_BIT]); // R9
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (lvl >= LVL_W'(1) && lvl <= LVL_MAX)); // R10
   AST_RSP_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> (st == CH_WAIT)); // R8
   AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin); // R8

endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int AW               = 32,
   parameter int OFF_W            = 16,
   parameter int FLAG_BIT         = AW - 1,
   parameter int MAX_LEVELS       = 8,
   parameter bit SIGNED_INDEX_OFF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [3:0]       mode,
   input  logic             size_byte,
   input  logic [OFF_W-1:0] offset,
   input  logic [AW-1:0]    reg_a,
   input  logic [AW-1:0]    reg_b,
   input  logic [AW-1:0]    pc,
   output logic             busy,
   output logic             done,
   output logic [AW-1:0]    result,
   output logic             err,
   output logic             wb_valid,
   output logic [AW-1:0]    wb_value,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [AW-1:0]    mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [AW-1:0]    mem_rsp_data
);

   generate
      if (AW < 16 || (AW % 8) != 0) begin : g_bad_aw
         $error("ea_unit: AW must be a multiple of 8 and at least 16");
      end
      if (FLAG_BIT >= AW || OFF_W > FLAG_BIT) begin : g_bad_flag
         $error("ea_unit: FLAG_BIT must lie above the offset field and inside AW");
      end
      if (MAX_LEVELS < 1) begin : g_bad_lvl
         $error("ea_unit: MAX_LEVELS must be at least 1");
      end
   endgenerate

   logic [AW-1:0] ea;
   logic          wb_en;
   logic [AW-1:0] wb_val;
   logic          need_mem;
   logic          bad_mode;
   logic          chain_busy;
   logic          fin;
   logic [AW-1:0] fin_addr;
   logic          fin_err;
   logic          accept;
   logic          launch;

   logic          done_q;
   logic [AW-1:0] res_q;
   logic          err_q;
   logic          wbv_q;
   logic [AW-1:0] wbval_q;

   ea_calc #(
      .AW(AW), .OFF_W(OFF_W), .SIGNED_INDEX_OFF(SIGNED_INDEX_OFF)
   ) u_calc (
      .mode(mode), .size_byte(size_byte), .offset(offset),
      .reg_a(reg_a), .reg_b(reg_b), .pc(pc),
      .ea(ea), .wb_en(wb_en), .wb_val(wb_val),
      .need_mem(need_mem), .bad_mode(bad_mode)
   );

   assign accept = start && !chain_busy;
   assign launch = accept && need_mem;

   ea_chain #(
      .AW(AW), .FLAG_BIT(FLAG_BIT), .MAX_LEVELS(MAX_LEVELS)
   ) u_chain (
      .clk(clk), .rst_n(rst_n),
      .launch(launch), .launch_addr(ea),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .busy(chain_busy), .fin(fin), .fin_addr(fin_addr), .fin_err(fin_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         res_q   <= '0;
         err_q   <= 1'b0;
         wbv_q   <= 1'b0;
         wbval_q <= '0;
      end else begin
         done_q <= 1'b0;
         wbv_q  <= 1'b0;
         if (accept && !need_mem) begin
            done_q  <= 1'b1;
            res_q   <= ea;
            err_q   <= bad_mode;
            wbv_q   <= wb_en;
            wbval_q <= wb_val;
         end
      end
   end

   assign busy     = chain_busy;
   assign done     = done_q | fin;
   assign result   = fin ? fin_addr : res_q;
   assign err      = fin ? fin_err : (done_q & err_q);
   assign wb_valid = wbv_q;
   assign wb_value = wbval_q;

   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_q && fin)); // R14
   AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (done && !err)); // R11
   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy); // R8
   AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done); // R14

endmodule

// File: tb/sim_ea_unit.sv
`timescale 1ns/1ps
module sim_ea_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic        size_byte = 1'b0;
   logic [15:0] offset = '0;
   logic [31:0] reg_a = '0, reg_b = '0, pc = '0;
   logic        busy, done, err, wb_valid, mem_req_valid;
   logic [31:0] result, wb_value, mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   ea_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size_byte(size_byte),
      .offset(offset), .reg_a(reg_a), .reg_b(reg_b), .pc(pc),
      .busy(busy), .done(done), .result(result), .err(err),
      .wb_valid(wb_valid), .wb_value(wb_value),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] sx(input logic [15:0] o);
      return {{16{o[15]}}, o};
   endfunction

   function automatic string tag_of(input int m);
      case (m)
         0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
         4: return "R6";  5: return "R6";  6: return "R7";  8: return "R11";
         9: return "R12"; default: return "R14";
      endcase
   endfunction

   task automatic run_direct(input int m, input bit sb, input logic [15:0] o,
                             input logic [31:0] ra, input logic [31:0] rb, input logic [31:0] p);
      logic [31:0] step, exp_r, exp_w;
      bit exp_wv, exp_e;
      string t;
      step = sb ? 32'd1 : 32'd4;
      exp_wv = 0; exp_w = 0; exp_e = 0;
      case (m)
         0, 1: exp_r = {16'h0, o};
         2: exp_r = ra;
         3: exp_r = ra + sx(o);
         4: exp_r = ra + rb;
         5: exp_r = ra + rb + sx(o);
         6: exp_r = p + sx(o);
         8: begin exp_r = ra; exp_wv = 1; exp_w = ra + step; end
         9: begin exp_r = ra - step; exp_wv = 1; exp_w = ra - step; end
         default: begin exp_r = 0; exp_e = 1; end
      endcase
      t = tag_of(m);
      @(negedge clk);
      mode = 4'(m); size_byte = sb; offset = o; reg_a = ra; reg_b = rb; pc = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done === 1'b1, t, {31'h0, done}, 32'h1);
      check(result === exp_r, t, result, exp_r);
      check(err === exp_e, t, {31'h0, err}, {31'h0, exp_e});
      check(wb_valid === exp_wv, t, {31'h0, wb_valid}, {31'h0, exp_wv});
      if (exp_wv) check(wb_value === exp_w, t, wb_value, exp_w);
      check(mem_req_valid === 1'b0 && busy === 1'b0, t, {31'h0, mem_req_valid}, 32'h0);
   endtask

   // Runs mode 7 with n flagged words followed (if n < 8) by final word fw.
   task automatic run_chain(input logic [15:0] o, input int n, input logic [31:0] fw,
                            input bit poke_start, input string t);
      logic [31:0] exp_addr, word, last;
      int reads = 0;
      int dones = 0;
      bit exp_e;
      exp_e = (n >= 8);
      exp_addr = {16'h0, o};
      last = 32'h0;
      @(negedge clk);
      mode = 4'd7; offset = o; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc < 200; cyc++) begin
         if (done) begin dones++; break; end
         if (mem_req_valid) begin
            check(mem_req_addr === exp_addr, "R9", mem_req_addr, exp_addr);
            check(mem_req_addr[31] === 1'b0, "R9", mem_req_addr, exp_addr);
            if (reads == 0) begin
               if (poke_start) begin
                  mode = 4'd0; offset = 16'h00AA; start = 1'b1;
               end
               @(negedge clk);
               start = 1'b0;
               check(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R13", mem_req_addr, exp_addr);
               check(done === 1'b0, "R14", {31'h0, done}, 32'h0);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            if (reads < n) word = 32'h8000_0000 | (32'h0000_0400 * 32'(reads + 1) + 32'h10);
            else word = fw;
            last = word & 32'h7FFF_FFFF;
            exp_addr = last;
            mem_rsp_valid = 1'b1; mem_rsp_data = word;
            reads++;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
      check(dones == 1, t, 32'(dones), 32'h1);
      check(result === last, t, result, last);
      check(err === exp_e, t, {31'h0, err}, {31'h0, exp_e});
      check(reads == (exp_e ? 8 : n + 1), t, 32'(reads), exp_e ? 32'd8 : 32'(n + 1));
      @(negedge clk);
      check(done === 1'b0 && mem_req_valid === 1'b0, "R14", {31'h0, done}, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] offs [6];
      logic [31:0] regs [4];
      offs = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
      regs = '{32'h0000_0000, 32'hFFFF_FFFC, 32'h8000_0000, 32'h0001_0003};
      repeat (3) @(negedge clk);
      // R1: reset state
      check(done === 0 && err === 0 && wb_valid === 0 && mem_req_valid === 0 && busy === 0,
            "R1", {27'h0, done, err, wb_valid, mem_req_valid, busy}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done === 0 && busy === 0, "R1", {30'h0, done, busy}, 32'h0);
      // Direct modes R2..R7, R11, R12 sweep
      for (int m = 0; m < 10; m++) begin
         if (m == 7) continue;
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 4; j++)
               for (int s = 0; s < 2; s++)
                  run_direct(m, s[0], offs[i], regs[j], regs[3 - j] ^ 32'h0000_5A5A,
                             regs[j] + 32'h0000_2000);
      end
      // R14: illegal mode codes
      for (int m = 10; m < 16; m++) run_direct(m, 1'b0, 16'h4321, 32'h1111_2222, 32'h3, 32'h4);
      // R8: single-level indirect
      run_chain(16'h0100, 0, 32'h0ABC_DE00, 1'b0, "R8");
      run_chain(16'hFFFF, 0, 32'h7FFF_FFFC, 1'b0, "R8");
      // R9: chained indirection of several depths, with start poked while busy (R14)
      run_chain(16'h0200, 1, 32'h0000_3000, 1'b1, "R9");
      run_chain(16'h0300, 3, 32'h1234_5678, 1'b0, "R9");
      run_chain(16'h0400, 7, 32'h0000_00FC, 1'b1, "R9");
      // R10: eight flagged levels end with error
      run_chain(16'h0500, 8, 32'h0, 1'b0, "R10");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule